// File: doc/BRIEF.md
# LED Driver Protection and Open-Circuit Diagnostic Controller

This block sits between the PWM engine of a 16-channel constant-current LED driver and its output stage. It has two jobs. The first is open-circuit diagnosis. A detection command forces every channel on for a measurement window of programmable length. At the end of the window the block latches the per-channel comparator results into a status word. The serial interface can later copy that word into a shift stage and clock it out one bit per shift.

The second job is protection against a lost grayscale clock. The grayscale clock input is synchronized into the reference clock domain and its rising edges are detected there. A counter measures the gap since the last edge. If the gap reaches the timeout, all outputs are blanked. The first grayscale edge after a loss clears the blanking and sends a one-cycle restart pulse, which resets the PWM counters and comparators before normal output resumes. A configuration bit turns the timeout off.

Top module: `led_guard_ctrl`

## Requirements
- R1: After reset, `clk_lost`, `det_busy`, `pwm_restart` and `ser_out` are 0, and `drv_out` equals `pwm_in`.
- R2: A `det_start` pulse seen while no window is running drives `drv_out` to all ones (`det_busy`=1) for exactly `WIN_CYC` cycles, starting with the cycle after the pulse.
- R3: At the end of the window the block stores `open_cmp` into the status word, where bit i = 1 means channel i is open and 0 means normal.
- R4: A `det_start` pulse during a running window is ignored, and the window ends at its original time.
- R5: `err_load` copies the status word into the shift stage. `ser_out` shows stage bit 0, so channel 0 comes out first. Each `err_shift` moves the stage one bit toward bit 0 and enters `ser_in` at bit 15.
- R6: When no window is running and the clock is not lost, `drv_out` equals `pwm_in` every cycle.
- R7: With `tmo_disable`=0, if no grayscale rising edge is seen for `TIMEOUT_CYC` reference cycles, `clk_lost` goes to 1 and `drv_out` is all zeros.
- R8: With `tmo_disable`=1, `clk_lost` stays 0 however long the grayscale clock is idle.
- R9: The first grayscale rising edge seen while `clk_lost`=1 clears `clk_lost` and raises `pwm_restart` for exactly one cycle.
- R10: Loss blanking takes priority over a forced-on window, so `drv_out` is 0 while `clk_lost`=1.
- R11: A grayscale clock whose edges are spaced well below the timeout never raises `clk_lost`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| gclk_in | input | 1 | Grayscale clock, asynchronous to `clk` |
| tmo_disable | input | 1 | Configuration bit: 1 turns the loss timeout off |
| det_start | input | 1 | One-cycle detection command |
| open_cmp | input | 16 | Per-channel comparator results, 1 = output below threshold |
| pwm_in | input | 16 | Channel states from the PWM engine |
| err_load | input | 1 | Copy the status word into the shift stage |
| err_shift | input | 1 | Shift the stage by one bit |
| ser_in | input | 1 | Serial input from the upstream device |
| drv_out | output | 16 | Channel enables to the current sinks |
| ser_out | output | 1 | Serial output, stage bit 0 |
| clk_lost | output | 1 | Outputs blanked because the grayscale clock is lost |
| det_busy | output | 1 | Measurement window running |
| pwm_restart | output | 1 | One-cycle PWM counter reset on clock return |

## Verification
The assertions check the local invariants on every cycle. They confirm that a window opens only after a start command, that the captured status matches the comparator inputs on the window's last cycle, that the disable bit keeps the loss flag low, that loss is never declared in a cycle right after an edge, that every loss clearance brings a single restart pulse, and that a load presents status bit 0 on the serial output. Other properties hold only across a whole scenario, so only the bench can show them. These are the exact window length, the rejection of a second start command, the full bit order through sixteen shifts with the chain input, the timeout firing after the quiet interval and not before, and blanking taking priority over a forced window.

// File: rtl/led_guard_pkg.sv
package led_guard_pkg;

    typedef enum logic {
        DET_IDLE = 1'b0,
        DET_MEAS = 1'b1
    } det_state_t;

    typedef struct packed {
        logic lost;
        logic restart;
    } wd_flags_t;

    function automatic logic [15:0] blend_outputs(
        input logic        lost,
        input logic        forced,
        input logic [15:0] pwm
    );
        if (lost)
            return '0;
        else if (forced)
            return '1;
        else
            return pwm;
    endfunction

endpackage

// File: rtl/gclk_edge_sync.sv
module gclk_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic gclk_in,
    output logic rise
);
    logic [STAGES:0] sr;

    always_ff @(posedge clk) begin
        if (rst)
            sr <= '0;
        else
            sr <= {sr[STAGES-1:0], gclk_in};
    end

    assign rise = sr[STAGES-1] & ~sr[STAGES];
endmodule

// File: rtl/gclk_watchdog.sv
module gclk_watchdog
    import led_guard_pkg::*;
#(
    parameter int TIMEOUT_CYC = 100_000_000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      rise,
    input  logic      tmo_disable,
    output wd_flags_t flags
);
    localparam int TW = $clog2(TIMEOUT_CYC);

    logic [TW-1:0] gap_cnt;
    logic          lost_q;
    logic          restart_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt   <= '0;
            lost_q    <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            restart_q <= 1'b0;
            if (tmo_disable) begin
                gap_cnt <= '0;
                lost_q  <= 1'b0;
            end else if (rise) begin
                gap_cnt <= '0;
                if (lost_q) begin
                    lost_q    <= 1'b0;
                    restart_q <= 1'b1;
                end
            end else if (!lost_q) begin
                if (gap_cnt == TW'(TIMEOUT_CYC - 1))
                    lost_q <= 1'b1;
                else
                    gap_cnt <= gap_cnt + 1'b1;
            end
        end
    end

    assign flags.lost    = lost_q;
    assign flags.restart = restart_q;

    AST_DISABLE_HOLDS_OFF: assert property (@(posedge clk) disable iff (rst)
        tmo_disable |=> !lost_q); // R8
    AST_RESUME_PULSE: assert property (@(posedge clk) disable iff (rst)
        ($fell(lost_q) && !$past(tmo_disable)) |-> restart_q); // R9
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        restart_q |=> !restart_q); // R9
endmodule

// File: rtl/open_detect.sv
module open_detect
    import led_guard_pkg::*;
#(
    parameter int NCH     = 16,
    parameter int WIN_CYC = 200
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [NCH-1:0] open_cmp,
    output logic           busy,
    output logic [NCH-1:0] status
);
    localparam int CW = $clog2(WIN_CYC);

    det_state_t     state;
    logic [CW-1:0]  win_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= DET_IDLE;
            win_cnt <= '0;
            status  <= '0;
        end else begin
            case (state)
                DET_IDLE: begin
                    if (start) begin
                        state   <= DET_MEAS;
                        win_cnt <= '0;
                    end
                end
                DET_MEAS: begin
                    if (win_cnt == CW'(WIN_CYC - 1)) begin
                        state  <= DET_IDLE;
                        status <= open_cmp;
                    end else begin
                        win_cnt <= win_cnt + 1'b1;
                    end
                end
                default: state <= DET_IDLE;
            endcase
        end
    end

    assign busy = (state == DET_MEAS);

    AST_WINDOW_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start)); // R2
    AST_CAPTURE_AT_END: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> status == $past(open_cmp)); // R3
endmodule

// File: rtl/err_shifter.sv
module err_shifter #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           shift,
    input  logic           ser_in,
    input  logic [NCH-1:0] status,
    output logic           ser_out
);
    logic [NCH-1:0] stage;

    always_ff @(posedge clk) begin
        if (rst)
            stage <= '0;
        else if (load)
            stage <= status;
        else if (shift)
            stage <= {ser_in, stage[NCH-1:1]};
    end

    assign ser_out = stage[0];

    AST_LOAD_BIT0_FIRST: assert property (@(posedge clk) disable iff (rst)
        load |=> ser_out == $past(status[0])); // R5
endmodule

// File: rtl/led_guard_ctrl.sv
module led_guard_ctrl
    import led_guard_pkg::*;
#(
    parameter int NCH         = 16,
    parameter int SYNC_STAGES = 2,
    parameter int WIN_CYC     = 200,
    parameter int TIMEOUT_CYC = 100_000_000
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           gclk_in,
    input  logic           tmo_disable,
    input  logic           det_start,
    input  logic [NCH-1:0] open_cmp,
    input  logic [NCH-1:0] pwm_in,
    input  logic           err_load,
    input  logic           err_shift,
    input  logic           ser_in,
    output logic [NCH-1:0] drv_out,
    output logic           ser_out,
    output logic           clk_lost,
    output logic           det_busy,
    output logic           pwm_restart
);
    logic           g_rise;
    wd_flags_t      wd;
    logic [NCH-1:0] status_w;

    gclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .gclk_in(gclk_in), .rise(g_rise)
    );

    gclk_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wd (
        .clk(clk), .rst(rst), .rise(g_rise),
        .tmo_disable(tmo_disable), .flags(wd)
    );

    open_detect #(.NCH(NCH), .WIN_CYC(WIN_CYC)) u_det (
        .clk(clk), .rst(rst), .start(det_start), .open_cmp(open_cmp),
        .busy(det_busy), .status(status_w)
    );

    err_shifter #(.NCH(NCH)) u_shift (
        .clk(clk), .rst(rst), .load(err_load), .shift(err_shift),
        .ser_in(ser_in), .status(status_w), .ser_out(ser_out)
    );

    generate
        if (NCH == 16) begin : g_pkg_blend
            assign drv_out = blend_outputs(wd.lost, det_busy, pwm_in);
        end else begin : g_wide_blend
            assign drv_out = wd.lost ? '0 : (det_busy ? '1 : pwm_in);
        end
    endgenerate

    assign clk_lost    = wd.lost;
    assign pwm_restart = wd.restart;

    AST_LOSS_AFTER_QUIET: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_lost) |-> !$past(g_rise)); // R7
endmodule

// File: tb/led_guard_ctrl_bench.sv
module led_guard_ctrl_bench;
    localparam int NCH = 16;
    localparam int WIN = 24;
    localparam int TMO = 64;

    logic           clk = 0;
    logic           rst = 1;
    logic           gclk_in = 0;
    logic           gclk_en = 1;
    logic           tmo_disable = 0;
    logic           det_start = 0;
    logic [NCH-1:0] open_cmp = '0;
    logic [NCH-1:0] pwm_in = '0;
    logic           err_load = 0;
    logic           err_shift = 0;
    logic           ser_in = 0;
    logic [NCH-1:0] drv_out;
    logic           ser_out, clk_lost, det_busy, pwm_restart;

    int n_chk = 0;
    int n_bad = 0;

    led_guard_ctrl #(.NCH(NCH), .SYNC_STAGES(2), .WIN_CYC(WIN), .TIMEOUT_CYC(TMO)) u_led_guard_ctrl (
        .clk(clk), .rst(rst), .gclk_in(gclk_in), .tmo_disable(tmo_disable),
        .det_start(det_start), .open_cmp(open_cmp), .pwm_in(pwm_in),
        .err_load(err_load), .err_shift(err_shift), .ser_in(ser_in),
        .drv_out(drv_out), .ser_out(ser_out), .clk_lost(clk_lost),
        .det_busy(det_busy), .pwm_restart(pwm_restart)
    );

    always #5 clk = ~clk;
    always #20 if (gclk_en) gclk_in = ~gclk_in;

    function automatic logic [NCH-1:0] exp_drv(input logic lost, input logic busy,
                                               input logic [NCH-1:0] pwm);
        if (lost) return '0;
        if (busy) return '1;
        return pwm;
    endfunction

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic run_window(input logic [NCH-1:0] pat, input logic second_start);
        int seen;
        int ones;
        open_cmp = pat;
        det_start = 1;
        @(negedge clk);
        det_start = 0;
        seen = 0;
        ones = 0;
        for (int i = 0; i < WIN + 6; i++) begin
            pwm_in = NCH'($urandom);
            if (second_start && i == WIN / 2) det_start = 1;
            #1;
            if (det_busy) seen++;
            if (det_busy && drv_out == '1) ones++;
            @(negedge clk);
            det_start = 0;
        end
        check(seen == WIN, second_start ? "R4 restart ignored" : "R2 window length", seen, WIN);
        check(ones == WIN, "R2 forced on", ones, WIN);
    endtask

    task automatic read_status(input logic [NCH-1:0] exp, input string req);
        logic [NCH-1:0] got;
        logic [NCH-1:0] chain;
        logic [NCH-1:0] back;
        chain = NCH'($urandom);
        err_load = 1;
        @(negedge clk);
        err_load = 0;
        for (int i = 0; i < NCH; i++) begin
            #1 got[i] = ser_out;
            ser_in = chain[i];
            err_shift = 1;
            @(negedge clk);
            err_shift = 0;
        end
        check(got == exp, req, got, exp);
        for (int i = 0; i < NCH; i++) begin
            #1 back[i] = ser_out;
            err_shift = 1;
            @(negedge clk);
            err_shift = 0;
        end
        check(back == chain, "R5 chain input order", back, chain);
    endtask

    initial begin
        int seed_val;
        seed_val = $urandom(32'd5031);
        tick(4);
        rst = 0;
        @(negedge clk);
        #1;
        check(clk_lost == 0 && det_busy == 0 && pwm_restart == 0 && ser_out == 0,
              "R1 reset outputs", {clk_lost, det_busy, pwm_restart, ser_out}, 0);
        check(drv_out == pwm_in, "R1 pass-through", drv_out, pwm_in);

        // R6 and R11: random pass-through with a running grayscale clock
        begin
            int bad;
            int lost_seen;
            bad = 0;
            lost_seen = 0;
            for (int i = 0; i < 300; i++) begin
                pwm_in = NCH'($urandom);
                #1;
                if (drv_out != exp_drv(1'b0, 1'b0, pwm_in)) bad++;
                if (clk_lost) lost_seen++;
                @(negedge clk);
            end
            check(bad == 0, "R6 pass-through", bad, 0);
            check(lost_seen == 0, "R11 running clock", lost_seen, 0);
        end

        // R2, R3: directed corners and random patterns
        run_window(16'h0000, 1'b0);
        read_status(16'h0000, "R3 all normal");
        run_window(16'hFFFF, 1'b0);
        read_status(16'hFFFF, "R3 all open");
        run_window(16'h8001, 1'b1);
        read_status(16'h8001, "R3 after R4 window");
        for (int k = 0; k < 4; k++) begin
            logic [NCH-1:0] p;
            p = NCH'($urandom);
            run_window(p, 1'b0);
            read_status(p, "R3 random pattern");
        end

        // R8: disabled timeout with clock stopped
        tmo_disable = 1;
        gclk_en = 0;
        begin
            int lost_seen;
            lost_seen = 0;
            for (int i = 0; i < 4 * TMO; i++) begin
                pwm_in = NCH'($urandom);
                #1;
                if (clk_lost || drv_out != pwm_in) lost_seen++;
                @(negedge clk);
            end
            check(lost_seen == 0, "R8 disabled timeout", lost_seen, 0);
        end

        // R7: timeout fires after the quiet interval, not before
        tmo_disable = 0;
        tick(TMO / 2);
        #1 check(clk_lost == 0, "R7 early", clk_lost, 0);
        tick(TMO);
        pwm_in = '1;
        #1;
        check(clk_lost == 1, "R7 lost", clk_lost, 1);
        check(drv_out == '0, "R7 blanked", drv_out, 0);

        // R10: forced window during loss stays dark
        det_start = 1;
        @(negedge clk);
        det_start = 0;
        begin
            int lit;
            lit = 0;
            for (int i = 0; i < WIN / 2; i++) begin
                #1 if (drv_out != '0) lit++;
                @(negedge clk);
            end
            check(lit == 0, "R10 blank over window", lit, 0);
        end
        tick(WIN);

        // R9: clock returns
        gclk_en = 1;
        begin
            int pulses;
            pulses = 0;
            for (int i = 0; i < 40; i++) begin
                #1 if (pwm_restart) pulses++;
                @(negedge clk);
            end
            check(pulses == 1, "R9 restart pulse", pulses, 1);
            pwm_in = NCH'($urandom);
            #1;
            check(clk_lost == 0, "R9 lost cleared", clk_lost, 0);
            check(drv_out == pwm_in, "R9 outputs resume", drv_out, pwm_in);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule